// File: doc/BRIEF.md
# Platform Interrupt Controller

This block collects a parameterised set of external interrupt sources and routes them to a parameterised set of hart contexts. Every source has a priority. Every context has three things of its own: an enable vector, a priority threshold and a claim/complete register. Software reaches all of this state through a simple 32-bit register bus. The block gives each context one registered interrupt line. That line is high while the context has at least one source that is pending, enabled and above its threshold.

Each source enters through a gateway. A gateway is built either for level signals or for rising edges. It forwards one request at a time and holds back any further request until software completes the previous one. To take service, software reads the claim register of a context. The read returns the winning source ID and clears that source's pending bit. When service is done, software writes the same ID back to the same register.

Source ID 0 does not exist. Valid source IDs run from 1 up to `NSRC`, and `NSRC` is at most 1024. Only one bus operation takes place per cycle.

Top module: `plat_irq_ctrl`

## Requirements
- R1: After reset, all of the following read as 0 and every context line is low: every priority, every enable bit, every threshold and every claim read.
- R2: The priority of source n is at byte address 4*n. It keeps the low `PRIO_W` bits of a write and reads back zero-extended. Address 0 (source 0) always reads 0 and ignores writes.
- R3: The enable bit for source n in context c is at address 0x2000 + 0x80*c + 4*(n/32), bit n%32. Bit 0 of word 0 and bits for IDs above `NSRC` read 0.
- R4: The threshold of context c is a read/write register at 0x200000 + 0x1000*c. The claim/complete register of context c is at that address + 4.
- R5: A source counts for a context only if its priority is strictly greater than that context's threshold. A priority of 0 never counts.
- R6: A claim read returns the ID of the qualifying source with the highest priority. On equal priorities the lowest ID wins. The read clears that source's pending bit. When no source qualifies, the read returns 0.
- R7: A claimed source is not presented again until its ID is written to a claim/complete register.
- R8: A completion write is ignored if it names a source that is not in service, whether that source is pending or idle.
- R9: An edge source becomes pending on a rising edge. While the source is blocked it stores exactly one further rising edge, and that edge is presented after completion. Further edges while blocked are lost.
- R10: A level source is presented again after completion if its input is still high. It is not presented again if the input is low.
- R11: A context line rises on the second clock edge after the source input goes high. It falls at the same edge that claims the last qualifying source.
- R12: Enables are separate for each context. A context never sees or claims a source it has not enabled. Any context that has enabled a pending source may claim it.
- R13: Read data appears on `reg_rdata` after the clock edge that takes the read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Source inputs; bit n is source n |
| reg_sel | input | 1 | Bus operation this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ctx_irq | output | NCTX | Interrupt line per context |

## Verification
The checker relies on two properties of the inputs. First, only one bus operation occurs per cycle, so a claim and a completion never fall in the same cycle. Second, the source inputs are synchronous to `clk`. The bench keeps within both: it drives every input on the falling edge and issues one register operation at a time, with an idle cycle between operations. The sweeps cover every pair of priorities between two level sources and every combination of priority and threshold for one source. Directed sequences cover edge latching, stray completions and line timing across both contexts.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTL_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTL_STRIDE = 32'h0000_1000;
  localparam int          MAX_SRC    = 1024;

  typedef enum logic [2:0] {D_NONE, D_PRIO, D_EN, D_THR, D_CLAIM} dkind_e;

  typedef struct packed {
    dkind_e      kind;
    logic [15:0] idx;  // source id or context number
    logic [4:0]  sub;  // enable word within a context
  } dec_t;

  // Map a byte address onto a register class and its indices.
  function automatic dec_t decode_addr(logic [31:0] a, int unsigned nsrc,
                                       int unsigned nctx);
    dec_t d;
    logic [31:0] off;
    d = '{kind: D_NONE, idx: '0, sub: '0};
    if (a < 32'h0000_1000) begin
      if (a[31:2] >= 30'd1 && a[31:2] <= 30'(nsrc)) begin
        d.kind = D_PRIO;
        d.idx  = 16'(a[31:2]);
      end
    end else if (a >= EN_BASE && a < EN_BASE + 32'(nctx) * EN_STRIDE) begin
      off    = a - EN_BASE;
      d.kind = D_EN;
      d.idx  = 16'(off >> 7);
      d.sub  = a[6:2];
    end else if (a >= CTL_BASE && a < CTL_BASE + 32'(nctx) * CTL_STRIDE) begin
      off   = a - CTL_BASE;
      d.idx = 16'(off >> 12);
      if (a[11:0] == 12'h000)      d.kind = D_THR;
      else if (a[11:0] == 12'h004) d.kind = D_CLAIM;
    end
    return d;
  endfunction
endpackage

// File: rtl/pic_gateway.sv
module pic_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic claim,
  input  logic done,
  output logic pend_o,
  output logic busy_o
);
  logic prev_q, held_q;
  logic open_g, rise, req;

  assign open_g = !pend_o && !busy_o;
  assign rise   = src && !prev_q;
  assign req    = EDGE ? (rise || held_q) : src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      prev_q <= src;
      if (claim) begin
        pend_o <= 1'b0;
        busy_o <= 1'b1;
      end else if (open_g && req) begin
        pend_o <= 1'b1;
      end
      if (done && busy_o) busy_o <= 1'b0;
      if (!EDGE)                held_q <= 1'b0;
      else if (open_g && req)   held_q <= 1'b0;
      else if (rise && !open_g) held_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int IDW    = 4
) (
  input  logic [NSRC:0]             pend,
  input  logic [NSRC:0]             en,
  input  logic [NSRC:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]         thr,
  input  logic [NSRC:0]             drop,
  output logic [IDW-1:0]            best_id,
  output logic                      fire
);
  logic [PRIO_W-1:0] bp;

  always_comb begin
    best_id = '0;
    bp      = thr;
    fire    = 1'b0;
    for (int i = 1; i <= NSRC; i++) begin
      if (pend[i] && en[i] && prio[i] > thr && !drop[i]) fire = 1'b1;
      if (pend[i] && en[i] && prio[i] > bp) begin
        best_id = IDW'(i);
        bp      = prio[i];
      end
    end
  end
endmodule

// File: rtl/plat_irq_ctrl.sv
module plat_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int AW     = 26,
  parameter logic [NSRC:1] EDGE_MASK = {{(NSRC/2){1'b1}}, {(NSRC-NSRC/2){1'b0}}}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   src_irq,
  input  logic            reg_sel,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [NCTX-1:0] ctx_irq
);
  localparam int IDW = $clog2(NSRC + 1);
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1;

  initial begin
    if (NSRC < 1 || NSRC > MAX_SRC) $error("NSRC out of range");
  end

  logic [NSRC:0][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC:0]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;

  logic [NSRC:0] pend, busy, claim_vec, done_vec;
  logic [NCTX-1:0][IDW-1:0] best_id;
  logic [NCTX-1:0] fire;

  dec_t           dec;
  logic [CW-1:0]  dc;
  logic [IDW-1:0] did;
  logic [31:0]    en_rd;

  assign dec = decode_addr(32'(reg_addr), NSRC, NCTX);
  assign dc  = dec.idx[CW-1:0];
  assign did = dec.idx[IDW-1:0];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (reg_sel && reg_wr) begin
      case (dec.kind)
        D_PRIO: prio_q[did] <= reg_wdata[PRIO_W-1:0];
        D_THR:  thr_q[dc]   <= reg_wdata[PRIO_W-1:0];
        D_EN: begin
          for (int b = 0; b < 32; b++) begin
            automatic int id = int'(dec.sub) * 32 + b;
            if (id >= 1 && id <= NSRC) en_q[dc][IDW'(id)] <= reg_wdata[b];
          end
        end
        default: ;
      endcase
    end
  end

  // Enable word gather for reads
  always_comb begin
    en_rd = '0;
    for (int b = 0; b < 32; b++) begin
      automatic int id = int'(dec.sub) * 32 + b;
      if (id >= 1 && id <= NSRC) en_rd[b] = en_q[dc][IDW'(id)];
    end
  end

  // Claim and completion events
  always_comb begin
    claim_vec = '0;
    done_vec  = '0;
    if (reg_sel && dec.kind == D_CLAIM) begin
      if (!reg_wr) begin
        if (best_id[dc] != '0) claim_vec[best_id[dc]] = 1'b1;
      end else if (reg_wdata >= 32'd1 && reg_wdata <= 32'(NSRC)) begin
        done_vec[reg_wdata[IDW-1:0]] = 1'b1;
      end
    end
  end

  // Read data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_sel && !reg_wr) begin
      case (dec.kind)
        D_PRIO:  reg_rdata <= 32'(prio_q[did]);
        D_EN:    reg_rdata <= en_rd;
        D_THR:   reg_rdata <= 32'(thr_q[dc]);
        D_CLAIM: reg_rdata <= 32'(best_id[dc]);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // Gateways
  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;
  for (genvar i = 1; i <= NSRC; i++) begin : g_src
    pic_gateway #(.EDGE(EDGE_MASK[i])) u_gw (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_irq[i]),
      .claim  (claim_vec[i]),
      .done   (done_vec[i]),
      .pend_o (pend[i]),
      .busy_o (busy[i])
    );
  end

  // Per-context arbitration and interrupt line
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    pic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_arb (
      .pend    (pend),
      .en      (en_q[c]),
      .prio    (prio_q),
      .thr     (thr_q[c]),
      .drop    (claim_vec),
      .best_id (best_id[c]),
      .fire    (fire[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctx_irq <= '0;
    else        ctx_irq <= fire;
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NSRC = 8,
  parameter int NCTX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC:0]   pend,
  input logic [NSRC:0]   busy,
  input logic [NSRC:0]   claim_vec,
  input logic [NSRC:0]   done_vec,
  input logic [NCTX-1:0] ctx_irq
);
  AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec)); // R6
  AST_CLAIM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vec & ~pend) == '0); // R6
  AST_NO_REPRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_irq != '0) |-> $past(pend != '0)); // R11

  for (genvar i = 1; i <= NSRC; i++) begin : g_s
    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      claim_vec[i] |=> (busy[i] && !pend[i])); // R7
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vec[i] && busy[i]) |=> !busy[i]); // R7
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_vec[i] && !busy[i]) |=> !busy[i]); // R8
  end
endmodule

bind plat_irq_ctrl pic_checker #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend      (pend),
  .busy      (busy),
  .claim_vec (claim_vec),
  .done_vec  (done_vec),
  .ctx_irq   (ctx_irq)
);

// File: tb/plat_irq_ctrl_test.sv
module plat_irq_ctrl_test;
  localparam int NSRC = 8, NCTX = 2, AW = 26;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [NSRC:1]   src = '0;
  logic            sel = 1'b0, wr = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCTX-1:0] irq;

  int n_chk = 0, n_bad = 0;

  plat_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_irq(src), .reg_sel(sel), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .ctx_irq(irq)
  );

  function automatic logic [31:0] a_prio(int id); return 32'(4 * id); endfunction
  function automatic logic [31:0] a_en(int c, int w); return 32'h2000 + 32'(c * 128 + w * 4); endfunction
  function automatic logic [31:0] a_thr(int c); return 32'h200000 + 32'(c * 4096); endfunction
  function automatic logic [31:0] a_clm(int c); return a_thr(c) + 32'd4; endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_w(logic [31:0] a, logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic reg_r(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a[AW-1:0];
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic pulse(int id);
    @(negedge clk); src[id] = 1'b1;
    @(negedge clk); src[id] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int exp;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    reg_r(a_prio(3), d); check("R1 prio", d, 0);
    reg_r(a_en(0, 0), d); check("R1 enable", d, 0);
    reg_r(a_thr(1), d); check("R1 thr", d, 0);
    reg_r(a_clm(0), d); check("R1 claim", d, 0);

    // R2 priority layout and width
    reg_w(a_prio(3), 32'hFFFF_FFFD);
    reg_r(a_prio(3), d); check("R2 prio mask", d, 5);
    reg_w(a_prio(0), 7);
    reg_r(a_prio(0), d); check("R2 source0", d, 0);
    reg_r(a_prio(NSRC + 1), d); check("R13 unmapped", d, 0);
    reg_w(a_prio(3), 0);

    // R3 enable layout, R4 threshold
    reg_w(a_en(1, 0), 32'hFFFF_FFFF);
    reg_r(a_en(1, 0), d); check("R3 enable word0", d, 32'h1FE);
    reg_r(a_en(1, 1), d); check("R3 enable word1", d, 0);
    reg_w(a_en(1, 0), 0);
    reg_w(a_thr(1), 6);
    reg_r(a_thr(1), d); check("R4 thr", d, 6);
    reg_w(a_thr(1), 0);

    // R5 threshold sweep on level source 3, context 0
    reg_w(a_en(0, 0), 32'h1 << 3);
    src[3] = 1'b1;
    for (int p = 0; p < 8; p++) begin
      reg_w(a_prio(3), p);
      for (int t = 0; t < 8; t++) begin
        reg_w(a_thr(0), t);
        idle(2);
        check("R5 strict threshold", 32'(irq[0]), (p > t) ? 1 : 0);
      end
    end
    reg_w(a_thr(0), 0);
    reg_w(a_prio(3), 1);
    src[3] = 1'b0;
    reg_r(a_clm(0), d); check("R6 single claim", d, 3);
    reg_w(a_clm(0), 3);
    idle(2);
    reg_r(a_clm(0), d); check("R10 level low", d, 0);

    // R6 priority pair sweep on level sources 1 and 2
    reg_w(a_en(0, 0), (32'h1 << 1) | (32'h1 << 2));
    src[1] = 1'b1; src[2] = 1'b1;
    idle(2);
    for (int p1 = 0; p1 < 8; p1++) begin
      for (int p2 = 0; p2 < 8; p2++) begin
        reg_w(a_prio(1), p1);
        reg_w(a_prio(2), p2);
        exp = (p1 == 0 && p2 == 0) ? 0 : ((p1 >= p2) ? 1 : 2);
        reg_r(a_clm(0), d);
        check("R6 arbitration", d, exp);
        if (d != 0) reg_w(a_clm(0), d);
      end
    end
    src[1] = 1'b0; src[2] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      reg_r(a_clm(0), d);
      if (d != 0) reg_w(a_clm(0), d);
    end
    reg_r(a_clm(0), d); check("R6 drained", d, 0);

    // R10 level re-presentation
    reg_w(a_prio(1), 2);
    src[1] = 1'b1;
    idle(2);
    reg_r(a_clm(0), d); check("R10 first", d, 1);
    reg_w(a_clm(0), 1);
    idle(3);
    reg_r(a_clm(0), d); check("R10 still high", d, 1);
    src[1] = 1'b0;
    reg_w(a_clm(0), 1);
    idle(3);
    reg_r(a_clm(0), d); check("R10 dropped", d, 0);

    // R9 edge latching on source 5
    reg_w(a_en(0, 0), (32'h1 << 5) | (32'h1 << 6));
    reg_w(a_prio(5), 4);
    reg_w(a_prio(6), 3);
    pulse(5);
    idle(2);
    reg_r(a_clm(0), d); check("R9 edge claim", d, 5);
    pulse(5); idle(1); pulse(5);
    idle(2);
    reg_r(a_clm(0), d); check("R7 blocked while busy", d, 0);
    reg_w(a_clm(0), 5);
    idle(3);
    reg_r(a_clm(0), d); check("R9 latched edge", d, 5);
    reg_w(a_clm(0), 5);
    idle(3);
    reg_r(a_clm(0), d); check("R9 one edge only", d, 0);

    // R8 stray completions on source 6
    pulse(6);
    idle(2);
    reg_w(a_clm(0), 6);
    reg_r(a_clm(0), d); check("R8 pending kept", d, 6);
    reg_w(a_clm(0), 7);
    pulse(6);
    idle(2);
    reg_r(a_clm(0), d); check("R8 still busy", d, 0);
    reg_w(a_clm(0), 6);
    idle(3);
    reg_r(a_clm(0), d); check("R8 after real done", d, 6);
    reg_w(a_clm(0), 6);

    // R11 / R12 line timing and context separation, source 7
    reg_w(a_en(0, 0), 0);
    reg_w(a_en(1, 0), 32'h1 << 7);
    reg_w(a_prio(7), 5);
    idle(1);
    src[7] = 1'b1;
    @(negedge clk);
    check("R11 not yet", 32'(irq), 0);
    src[7] = 1'b0;
    @(negedge clk);
    check("R11 R12 rise ctx1 only", 32'(irq), 2);
    reg_r(a_clm(0), d); check("R12 ctx0 blind", d, 0);
    reg_r(a_clm(1), d); check("R12 ctx1 claim", d, 7);
    check("R11 drop", 32'(irq), 0);
    reg_w(a_clm(1), 7);
    reg_w(a_en(0, 0), 32'h1 << 7);
    pulse(7);
    idle(2);
    check("R12 both lines", 32'(irq), 3);
    reg_r(a_clm(0), d); check("R12 shared claim", d, 7);
    check("R11 both drop", 32'(irq), 0);
    reg_w(a_clm(1), 7);
    idle(3);
    reg_r(a_clm(1), d); check("R12 nothing left", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule